// File: doc/BRIEF.md
# Complementary Half-Bridge PWM with Dead-Time Insertion

This block drives the high-side and low-side switches of one half-bridge leg from a single duty word. Every PWM period is a fixed sequence of four phases: output `pwm_a` is driven high for a number of clocks equal to the duty word. Both outputs are then held low for a dead-time gap. Next, `pwm_b` is driven high for a number of clocks equal to the bitwise complement of the duty word. A second dead-time gap, with both outputs low, closes the period. The dead time is a fixed number of clocks set by a parameter (100 clocks by default, about 1 µs at 100 MHz).

The sum of the two pulse widths always equals the duty full scale, 2^DUTY_W − 1. The period is therefore constant at full scale plus two dead times. The duty input is captured only on the clock that starts a period. A phase of zero length is dropped, and both dead-time gaps are still inserted. Both outputs come straight from flip-flops.

Top module: `cpwm_deadtime`

## Requirements
- R1: While `rst` is high, both outputs are low after the next clock edge. On the first clock edge after `rst` falls, a new period starts with the channel A phase.
- R2: In each period, `pwm_a` is high for exactly D clocks, at the start of the period. D is the duty word captured at the start of that period, read as an unsigned number.
- R3: After the channel A phase, both outputs are low for exactly DEAD_CLKS clocks.
- R4: After the first gap, `pwm_b` is high for exactly (2^DUTY_W − 1) − D clocks, which is the bitwise complement of D.
- R5: After the channel B phase, both outputs are low for exactly DEAD_CLKS clocks. The next period then starts, so every period lasts (2^DUTY_W − 1) + 2·DEAD_CLKS clocks.
- R6: `pwm_a` and `pwm_b` are never high on the same clock.
- R7: The duty input is sampled only on the clock that starts a period. A change at any other time has no effect on the current period.
- R8: With D = 0, `pwm_a` stays low for the whole period, and the period opens with the first gap. With D = 2^DUTY_W − 1, `pwm_b` stays low, and the two gaps run back to back for 2·DEAD_CLKS low clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| duty | input | DUTY_W | Duty word that sets the channel A width; its complement sets the channel B width |
| pwm_a | output | 1 | Channel A (high-side) drive, registered, active high |
| pwm_b | output | 1 | Channel B (low-side) drive, registered, active high |

## Verification
Some properties are checked on every clock, at the output pins only:
- the two outputs never overlap;
- outputs are low after reset;
- at least a full dead time of low clocks comes before every rising edge;
- no pulse is wider than full scale;
- rising edges of channel A are spaced by whole periods.

Other behaviour needs the bench's scenarios. These cover the exact pulse widths for a given duty word, capture of the duty word only at the start of a period while it changes randomly mid-period, the skipped phases at zero and full-scale duty, and the restart after a reset in the middle of a period.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    // Phase order within one PWM period; the sequence is part of the behaviour.
    typedef enum logic [1:0] {
        PH_A    = 2'd0,
        PH_GAP1 = 2'd1,
        PH_B    = 2'd2,
        PH_GAP2 = 2'd3
    } phase_e;

    typedef struct packed {
        logic a;
        logic b;
    } leg_t;

    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    // Output levels that belong to a phase: only the two pulse phases drive a leg.
    function automatic leg_t leg_for(input phase_e p);
        leg_t l;
        l.a = (p == PH_A);
        l.b = (p == PH_B);
        return l;
    endfunction

endpackage

// File: rtl/cpwm_width.sv
module cpwm_width
    import cpwm_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DUTY_W-1:0] duty_in,
    output logic [DUTY_W-1:0] len_a,
    output logic [DUTY_W-1:0] len_b
);

    logic [DUTY_W-1:0] duty_q;

    // Capture the duty word once per period.
    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
        end else if (load) begin
            duty_q <= duty_in;
        end
    end

    // On the loading clock the A width comes straight from the input.
    always_comb begin
        len_a = load ? duty_in : duty_q;
        len_b = ~duty_q;
    end

endmodule

// File: rtl/cpwm_seq.sv
module cpwm_seq
    import cpwm_pkg::*;
#(
    parameter int DUTY_W    = 8,
    parameter int DEAD_CLKS = 100,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] len_a,
    input  logic [DUTY_W-1:0] len_b,
    output logic              load,
    output phase_e            nxt_phase
);

    localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(DEAD_CLKS - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;     // clocks left in the phase after the current one
    logic             pend_q;    // a period start is due (after reset)
    logic [CNT_W-1:0] nxt_cnt;
    logic             last;

    assign last = pend_q || (cnt_q == '0);

    always_comb begin
        nxt_phase = phase_q;
        nxt_cnt   = cnt_q - ONE;
        load      = 1'b0;
        if (last) begin
            if (pend_q || phase_q == PH_GAP2) begin
                load = 1'b1;
                if (len_a != '0) begin
                    nxt_phase = PH_A;
                    nxt_cnt   = CNT_W'(len_a) - ONE;
                end else begin
                    nxt_phase = PH_GAP1;
                    nxt_cnt   = GAP_LOAD;
                end
            end else begin
                unique case (phase_q)
                    PH_A: begin
                        nxt_phase = PH_GAP1;
                        nxt_cnt   = GAP_LOAD;
                    end
                    PH_GAP1: begin
                        if (len_b != '0) begin
                            nxt_phase = PH_B;
                            nxt_cnt   = CNT_W'(len_b) - ONE;
                        end else begin
                            nxt_phase = PH_GAP2;
                            nxt_cnt   = GAP_LOAD;
                        end
                    end
                    default: begin
                        nxt_phase = PH_GAP2;
                        nxt_cnt   = GAP_LOAD;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_A;
            cnt_q   <= '0;
            pend_q  <= 1'b1;
        end else begin
            phase_q <= nxt_phase;
            cnt_q   <= nxt_cnt;
            pend_q  <= 1'b0;
        end
    end

endmodule

// File: rtl/cpwm_drive.sv
module cpwm_drive
    import cpwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e nxt_phase,
    output leg_t   leg_q
);

    // Registered outputs: decoded from the next phase so they line up with it.
    always_ff @(posedge clk) begin
        if (rst) begin
            leg_q <= '0;
        end else begin
            leg_q <= leg_for(nxt_phase);
        end
    end

endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime
    import cpwm_pkg::*;
#(
    parameter int DUTY_W    = 8,
    parameter int DEAD_CLKS = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty,
    output logic              pwm_a,
    output logic              pwm_b
);

    localparam int CNT_W = imax(DUTY_W, $clog2(DEAD_CLKS + 1));

    logic [DUTY_W-1:0] len_a;
    logic [DUTY_W-1:0] len_b;
    logic              load;
    phase_e            nxt_phase;
    leg_t              leg;

    cpwm_width #(.DUTY_W(DUTY_W)) u_width (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .duty_in (duty),
        .len_a   (len_a),
        .len_b   (len_b)
    );

    cpwm_seq #(
        .DUTY_W    (DUTY_W),
        .DEAD_CLKS (DEAD_CLKS),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .len_a     (len_a),
        .len_b     (len_b),
        .load      (load),
        .nxt_phase (nxt_phase)
    );

    cpwm_drive u_drive (
        .clk       (clk),
        .rst       (rst),
        .nxt_phase (nxt_phase),
        .leg_q     (leg)
    );

    assign pwm_a = leg.a;
    assign pwm_b = leg.b;

endmodule

// File: rtl/cpwm_deadtime_chk.sv
module cpwm_deadtime_chk #(
    parameter int DUTY_W    = 8,
    parameter int DEAD_CLKS = 100
) (
    input logic clk,
    input logic rst,
    input logic pwm_a,
    input logic pwm_b
);

    localparam int FULL   = (1 << DUTY_W) - 1;
    localparam int PERIOD = FULL + 2 * DEAD_CLKS;

    logic [31:0] low_run, run_a, run_b, since_a;
    logic        a_prev, started, seen_a;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= '0;
            run_a   <= '0;
            run_b   <= '0;
            since_a <= '0;
            a_prev  <= 1'b0;
            started <= 1'b0;
            seen_a  <= 1'b0;
        end else begin
            low_run <= (!pwm_a && !pwm_b) ? ((low_run == 32'hFFFF_FFFF) ? low_run : low_run + 1) : '0;
            run_a   <= pwm_a ? run_a + 1 : '0;
            run_b   <= pwm_b ? run_b + 1 : '0;
            since_a <= (pwm_a && !a_prev) ? '0 : since_a + 1;
            a_prev  <= pwm_a;
            if (pwm_a || pwm_b) started <= 1'b1;
            if (pwm_a && !a_prev) seen_a <= 1'b1;
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(pwm_a && pwm_b)); // R6

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!pwm_a && !pwm_b)); // R1

    AST_GAP_BEFORE_B: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_b) |-> (low_run >= 32'(DEAD_CLKS))); // R3

    AST_GAP_BEFORE_A: assert property (@(posedge clk) disable iff (rst)
        ($rose(pwm_a) && started) |-> (low_run >= 32'(DEAD_CLKS))); // R5

    AST_A_WIDTH_MAX: assert property (@(posedge clk) disable iff (rst)
        $fell(pwm_a) |-> (run_a <= 32'(FULL))); // R2

    AST_B_WIDTH_MAX: assert property (@(posedge clk) disable iff (rst)
        $fell(pwm_b) |-> (run_b <= 32'(FULL))); // R4

    AST_PERIOD_GRID: assert property (@(posedge clk) disable iff (rst)
        ($rose(pwm_a) && seen_a) |-> (((since_a + 1) % 32'(PERIOD)) == 0)); // R5

endmodule

bind cpwm_deadtime cpwm_deadtime_chk #(
    .DUTY_W    (DUTY_W),
    .DEAD_CLKS (DEAD_CLKS)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .pwm_a (pwm_a),
    .pwm_b (pwm_b)
);

// File: tb/sim_cpwm_deadtime.sv
module sim_cpwm_deadtime;

    localparam int DW = 6;
    localparam int DT = 7;
    localparam int FS = (1 << DW) - 1;
    localparam int P  = FS + 2 * DT;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] duty = '0;
    logic          pwm_a, pwm_b;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cpwm_deadtime #(.DUTY_W(DW), .DEAD_CLKS(DT)) u0 (
        .clk   (clk),
        .rst   (rst),
        .duty  (duty),
        .pwm_a (pwm_a),
        .pwm_b (pwm_b)
    );

    // Expected {a,b} in slot s of a period captured with duty d.
    function automatic logic [1:0] exp_leg(input int d, input int s);
        logic ea, eb;
        ea = (s < d);
        eb = (s >= d + DT) && (s < d + DT + (FS - d));
        return {ea, eb};
    endfunction

    function automatic string slot_req(input int d, input int s);
        if (s < d) return "R2";
        if (s < d + DT) return "R3";
        if (s < FS + DT) return "R4";
        return "R5";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Called at a negedge just before the clock that starts a period.
    task automatic run_slots(input int d, input int n, input bit jitter);
        int ca = 0;
        int cb = 0;
        duty = DW'(d);
        for (int s = 0; s < n; s++) begin
            logic [1:0] e;
            @(posedge clk);
            @(negedge clk);
            e = exp_leg(d, s);
            ca += int'(pwm_a);
            cb += int'(pwm_b);
            check({pwm_a, pwm_b} == e,
                  jitter ? {slot_req(d, s), "/R7"} : slot_req(d, s),
                  $sformatf("slot %0d duty %0d {a,b}", s, d), {pwm_a, pwm_b}, e);
            if (pwm_a && pwm_b)
                check(1'b0, "R6", "overlap", 1, 0);
            if (jitter) duty = DW'($urandom % (FS + 1));
        end
        if (n == P) begin
            check(ca == d, (d == 0) ? "R8" : "R2", "A high count", ca, d);
            check(cb == FS - d, (d == FS) ? "R8" : "R4", "B high count", cb, FS - d);
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst  = 1'b1;
        duty = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!pwm_a && !pwm_b, "R1", "outputs in reset", {pwm_a, pwm_b}, 0);
        rst = 1'b0;

        // Directed periods, chained back to back (R1 first period starts with A).
        run_slots(20, P, 1'b0);
        run_slots(0, P, 1'b0);      // R8 zero duty
        run_slots(FS, P, 1'b0);     // R8 full-scale duty
        run_slots(1, P, 1'b0);
        run_slots(FS - 1, P, 1'b0);
        run_slots(37, P, 1'b1);     // R7 mid-period changes
        run_slots(FS, P, 1'b1);
        run_slots(0, P, 1'b1);

        for (int i = 0; i < 40; i++)
            run_slots(int'($urandom % (FS + 1)), P, ($urandom % 2) == 1);

        // Reset in the middle of a period, then a fresh start (R1).
        run_slots(30, 25, 1'b0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(!pwm_a && !pwm_b, "R1", "outputs after mid-run reset", {pwm_a, pwm_b}, 0);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        run_slots(50, P, 1'b1);
        run_slots(int'($urandom % (FS + 1)), P, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule